// File: doc/BRIEF.md
# Cache-Aware Variable-Length Index Decoder

This block turns a packed bit stream into a stream of full triangle-vertex indices. Each entry of the stream opens with a prefix-free code of at most HMAX bits. The decoded symbol has one of three meanings:
- It refers to one slot of a small FIFO that holds recently produced indices.
- It marks a vertex seen for the first time. That vertex takes the next value of a running counter.
- It marks a vertex that has to be fetched again. Its index then follows as a raw field whose width grows with the counter.

The cache holds only index numbers, never vertex data.

Software fills the code table through a write port before a stream begins. A one-cycle start pulse then opens a new stream. Input words arrive MSB first under a valid/ready handshake. The decoded indices leave one per beat under their own valid/ready handshake, from a registered output. A reference to a cache slot that holds nothing raises a sticky error flag.

Top module: `idx_stream_decoder`

## Requirements
- R1: The code table has 2^HMAX entries. Each entry is written at address `tbl_addr` with `tbl_sym` and `tbl_len`. Decoding looks up the next HMAX buffered bits and consumes only `tbl_len` of them. Any bits past that length are kept for the next symbol.
- R2: Symbol value CACHE_K means a first-use vertex. The block outputs the counter value and then increments the counter. The counter is 0 after reset or start.
- R3: Symbol value CACHE_K+1 means a reload. It is followed, MSB first, by a raw field of max(1, ceil(log2(counter))) bits, and that field is output as the index.
- R4: A symbol value s below CACHE_K outputs the index held in cache slot s. Slot 0 holds the newest entry.
- R5: Only first-use and reload outputs enter the cache. Each one goes into slot 0, shifts the other entries down one slot and drops the oldest. A slot hit leaves the order unchanged.
- R6: A slot symbol that points at an empty slot is consumed without producing an output beat. It sets `err`, and `err` stays high until the next start.
- R7: `start` empties every cache slot, zeroes the counter, clears `err` and throws away any buffered bits and any pending output.
- R8: While `out_valid` is high and `out_ready` is low, `out_idx` stays unchanged.
- R9: Input words of IN_W bits are taken MSB first. `in_ready` drops while the bit buffer cannot hold another word. A symbol is decoded only after all of its bits, raw field included, are buffered.
- R10: After reset, `out_valid` and `err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Opens a new stream |
| tbl_we | input | 1 | Code table write enable |
| tbl_addr | input | HMAX | Code table entry address |
| tbl_sym | input | clog2(CACHE_K+2) | Symbol stored in the entry |
| tbl_len | input | clog2(HMAX+1) | True code length stored in the entry |
| in_valid | input | 1 | Input word valid |
| in_data | input | IN_W | Input word, first bit in the MSB |
| in_ready | output | 1 | Buffer can take a word |
| out_valid | output | 1 | Decoded index valid |
| out_idx | output | IDX_W | Decoded vertex index |
| out_ready | input | 1 | Downstream takes the index |
| err | output | 1 | Sticky empty-slot reference flag |

## Verification
The assertions assume that the code table is fully loaded before a start pulse and is not rewritten while a stream is being decoded. They also assume that every stored length is nonzero and that the counter never wraps. The bench loads all 16 entries with a prefix-free set before its first start and keeps each stream far shorter than the index range. It holds input and output handshake signals steady from one falling edge to the next.

// File: rtl/isd_pkg.sv
`timescale 1ns/1ps
package isd_pkg;
  // Meaning of a decoded symbol
  typedef enum logic [1:0] {
    CLS_SLOT   = 2'd0,
    CLS_FIRST  = 2'd1,
    CLS_RELOAD = 2'd2,
    CLS_BAD    = 2'd3
  } sym_class_e;
endpackage

// File: rtl/isd_code_table.sv
`timescale 1ns/1ps
module isd_code_table #(
  parameter int HMAX  = 4,
  parameter int SYM_W = 4,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [HMAX-1:0]  waddr,
  input  logic [SYM_W-1:0] wsym,
  input  logic [LEN_W-1:0] wlen,
  input  logic [HMAX-1:0]  raddr,
  output logic [SYM_W-1:0] rsym,
  output logic [LEN_W-1:0] rlen
);
  localparam int DEPTH = 2 ** HMAX;
  logic [SYM_W+LEN_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wsym, wlen};
  end

  assign {rsym, rlen} = mem[raddr];
endmodule

// File: rtl/isd_bitbuf.sv
`timescale 1ns/1ps
module isd_bitbuf #(
  parameter int IN_W  = 8,
  parameter int BUF_W = 28,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_data,
  output logic             in_ready,
  input  logic [CNT_W-1:0] take,
  output logic [BUF_W-1:0] win,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] ROOM = CNT_W'(BUF_W - IN_W);
  localparam logic [CNT_W-1:0] WORD = CNT_W'(IN_W);

  logic             acc;
  logic [CNT_W-1:0] rem;
  logic [BUF_W-1:0] placed, nxt;

  assign in_ready = (cnt <= ROOM);
  assign acc      = in_valid && in_ready;

  always_comb begin
    rem    = cnt - take;
    placed = {in_data, {(BUF_W-IN_W){1'b0}}} >> rem;
    nxt    = (win << take) | (acc ? placed : '0);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      win <= '0;
      cnt <= '0;
    end else begin
      win <= nxt;
      cnt <= rem + (acc ? WORD : '0);
    end
  end
endmodule

// File: rtl/isd_slot_cache.sv
`timescale 1ns/1ps
module isd_slot_cache #(
  parameter int CACHE_K = 8,
  parameter int IDX_W   = 16,
  parameter int SLOT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              push,
  input  logic [IDX_W-1:0]  push_idx,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid
);
  logic [IDX_W-1:0] idx_q [CACHE_K];
  logic [CACHE_K-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst || clear) vld_q <= '0;
    else if (push)    vld_q <= {vld_q[CACHE_K-2:0], 1'b1};
  end

  always_ff @(posedge clk) begin
    if (push) idx_q[0] <= push_idx;
  end

  for (genvar i = 1; i < CACHE_K; i++) begin : g_shift
    always_ff @(posedge clk) begin
      if (push) idx_q[i] <= idx_q[i-1];
    end
  end

  assign rd_idx   = idx_q[rd_slot];
  assign rd_valid = vld_q[rd_slot];
endmodule

// File: rtl/idx_stream_decoder.sv
`timescale 1ns/1ps
module idx_stream_decoder #(
  parameter int CACHE_K = 8,
  parameter int HMAX    = $clog2(CACHE_K) + 1,
  parameter int IDX_W   = 16,
  parameter int IN_W    = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          tbl_we,
  input  logic [HMAX-1:0]               tbl_addr,
  input  logic [$clog2(CACHE_K+2)-1:0]  tbl_sym,
  input  logic [$clog2(HMAX+1)-1:0]     tbl_len,
  input  logic                          in_valid,
  input  logic [IN_W-1:0]               in_data,
  output logic                          in_ready,
  output logic                          out_valid,
  output logic [IDX_W-1:0]              out_idx,
  input  logic                          out_ready,
  output logic                          err
);
  import isd_pkg::*;

  localparam int SYM_W  = $clog2(CACHE_K + 2);
  localparam int LEN_W  = $clog2(HMAX + 1);
  localparam int SLOT_W = $clog2(CACHE_K);
  localparam int BUF_W  = HMAX + IDX_W + IN_W;
  localparam int CNT_W  = $clog2(BUF_W + 1);
  localparam logic [SYM_W-1:0] SYM_FIRST  = SYM_W'(CACHE_K);
  localparam logic [SYM_W-1:0] SYM_RELOAD = SYM_W'(CACHE_K + 1);

  logic [BUF_W-1:0]  win;
  logic [CNT_W-1:0]  buf_cnt, take, need, rw, rsh;
  logic [SYM_W-1:0]  sym;
  logic [LEN_W-1:0]  clen;
  logic [IDX_W-1:0]  g_cnt, gm1, raw, slot_idx, value;
  logic [BUF_W-1:0]  after, raw_full;
  logic              slot_ok, avail, fire, emit, push;
  sym_class_e        cls;

  isd_code_table #(.HMAX(HMAX), .SYM_W(SYM_W), .LEN_W(LEN_W)) u_tbl (
    .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wsym(tbl_sym), .wlen(tbl_len),
    .raddr(win[BUF_W-1 -: HMAX]), .rsym(sym), .rlen(clen)
  );

  isd_bitbuf #(.IN_W(IN_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_buf (
    .clk(clk), .rst(rst), .clear(start), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(take), .win(win), .cnt(buf_cnt)
  );

  isd_slot_cache #(.CACHE_K(CACHE_K), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_cache (
    .clk(clk), .rst(rst), .clear(start), .push(push), .push_idx(value),
    .rd_slot(sym[SLOT_W-1:0]), .rd_idx(slot_idx), .rd_valid(slot_ok)
  );

  // Classify the looked-up symbol
  always_comb begin
    if (sym == SYM_FIRST)                   cls = CLS_FIRST;
    else if (sym == SYM_RELOAD)             cls = CLS_RELOAD;
    else if (sym < SYM_W'(CACHE_K))         cls = CLS_SLOT;
    else                                    cls = CLS_BAD;
  end

  // Raw field width follows the counter, never below one bit
  always_comb begin
    gm1 = g_cnt - 1'b1;
    rw  = CNT_W'(1);
    if (g_cnt > IDX_W'(1)) begin
      for (int i = 0; i < IDX_W; i++) begin
        if (gm1[i]) rw = CNT_W'(i + 1);
      end
    end
  end

  always_comb begin
    after    = win << clen;
    rsh      = CNT_W'(BUF_W) - rw;
    raw_full = after >> rsh;
    raw      = raw_full[IDX_W-1:0];
    need     = CNT_W'(clen) + ((cls == CLS_RELOAD) ? rw : '0);
    avail    = (clen != '0) && (buf_cnt >= need);
    fire     = avail && (!out_valid || out_ready) && !start;
    take     = fire ? need : '0;
    push     = fire && (cls == CLS_FIRST || cls == CLS_RELOAD);
    emit     = push || (fire && cls == CLS_SLOT && slot_ok);
    case (cls)
      CLS_FIRST:  value = g_cnt;
      CLS_RELOAD: value = raw;
      default:    value = slot_idx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      g_cnt     <= '0;
      err       <= 1'b0;
    end else begin
      if (emit) begin
        out_valid <= 1'b1;
        out_idx   <= value;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (fire && cls == CLS_FIRST) g_cnt <= g_cnt + 1'b1;
      if (fire && !emit)            err   <= 1'b1;
    end
  end
endmodule

// File: rtl/isd_checker.sv
`timescale 1ns/1ps
module isd_checker #(
  parameter int IDX_W = 16,
  parameter int BUF_W = 28,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_idx,
  input logic             err,
  input logic [CNT_W-1:0] fill,
  input logic [IDX_W-1:0] gcount
);
  // R8: a stalled beat keeps its index
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_idx)));

  // R9: buffer fill never exceeds its capacity
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(BUF_W));

  // R7: start leaves an empty stream state
  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!out_valid && !err && gcount == '0 && fill == '0));

  // R6: the error flag only drops after a start
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $fell(err) |-> $past(start));

  // R2: the counter only advances by one outside a start
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(start) && gcount != $past(gcount)) |-> (gcount == $past(gcount) + 1'b1));
endmodule

bind idx_stream_decoder isd_checker #(.IDX_W(IDX_W), .BUF_W(BUF_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .out_valid(out_valid), .out_ready(out_ready),
  .out_idx(out_idx), .err(err), .fill(buf_cnt), .gcount(g_cnt)
);

// File: tb/sim_idx_stream_decoder.sv
`timescale 1ns/1ps
module sim_idx_stream_decoder;
  localparam int K = 8;
  localparam int NV = 18;
  // kind: 0 first-use, 1 reload, 2 slot hit
  localparam int V_KIND [NV] = '{0,0,0,2,2,0,1,2,0,1,2,0,0,2,2,0,1,2};
  localparam int V_ARG  [NV] = '{0,0,0,0,2,0,1,1,0,3,6,0,0,7,0,0,7,4};
  localparam int V_RW   [NV] = '{0,0,0,0,0,0,2,0,0,3,0,0,0,0,0,0,3,0};
  localparam int V_EXP  [NV] = '{0,1,2,2,0,3,1,3,4,3,0,5,6,1,6,7,7,3};

  logic clk = 0, rst = 1, start = 0, tbl_we = 0;
  logic [3:0] tbl_addr = 0, tbl_sym = 0;
  logic [2:0] tbl_len = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 0, err;
  logic [7:0] in_data = 0;
  logic [15:0] out_idx;

  always #2.5 clk = ~clk;

  idx_stream_decoder #(.CACHE_K(K)) u0 (
    .clk(clk), .rst(rst), .start(start), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_sym(tbl_sym), .tbl_len(tbl_len), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_idx(out_idx),
    .out_ready(out_ready), .err(err)
  );

  int total = 0, bad = 0, cyc = 0, mode = 0;
  int wptr = 0, nwords = 0, ngot = 0, nb = 0;
  bit acc_in = 0, done = 0;
  logic [7:0] words [64];
  int got [64];
  bit sbits [512];
  int held;

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    bit rdy;
    @(negedge clk);
    if (acc_in) wptr++;
    cyc++;
    in_valid = (wptr < nwords);
    in_data  = in_valid ? words[wptr] : 8'h00;
    acc_in   = in_valid && in_ready;
    rdy = (mode == 0) ? 1'b1 : (mode == 1) ? ((cyc % 3) != 0) : 1'b0;
    out_ready = rdy;
    if (out_valid && rdy && ngot < 64) begin
      got[ngot] = out_idx;
      ngot++;
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1; in_valid = 0; out_ready = 0; acc_in = 0;
    wptr = 0; nwords = 0; ngot = 0; nb = 0;
    for (int i = 0; i < 512; i++) sbits[i] = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic put(int v, int w);
    for (int i = w - 1; i >= 0; i--) begin
      sbits[nb] = v[i];
      nb++;
    end
  endtask

  task automatic seal();
    nwords = (nb + 7) / 8;
    for (int j = 0; j < nwords; j++)
      for (int b = 0; b < 8; b++) words[j][7-b] = sbits[8*j + b];
  endtask

  task automatic run_until(int n);
    for (int t = 0; t < 3000 && ngot < n; t++) tick();
  endtask

  // R1: prefix-free code set: first=00, reload=010, slot0=011, slot s>0 = 1 then (s-1) on 3 bits
  task automatic load_table();
    for (int a = 0; a < 16; a++) begin
      @(negedge clk);
      tbl_we = 1; tbl_addr = 4'(a);
      if (a < 4)       begin tbl_sym = 4'd8;      tbl_len = 3'd2; end
      else if (a < 6)  begin tbl_sym = 4'd9;      tbl_len = 3'd3; end
      else if (a < 8)  begin tbl_sym = 4'd0;      tbl_len = 3'd3; end
      else if (a < 15) begin tbl_sym = 4'(a - 7); tbl_len = 3'd4; end
      else             begin tbl_sym = 4'd15;     tbl_len = 3'd4; end
    end
    @(negedge clk);
    tbl_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(out_valid == 0, "R10 out_valid", int'(out_valid), 0);
    chk(err == 0, "R10 err", int'(err), 0);
    chk(in_ready == 1, "R10 in_ready", int'(in_ready), 1);

    load_table();

    // Vector walk under a stalling output
    do_start();
    for (int i = 0; i < NV; i++) begin
      case (V_KIND[i])
        0: put(0, 2);
        1: begin put(2, 3); put(V_ARG[i], V_RW[i]); end
        default: if (V_ARG[i] == 0) put(3, 3); else put(8 + V_ARG[i] - 1, 4);
      endcase
    end
    seal();
    mode = 1;
    run_until(NV);
    for (int i = 0; i < NV; i++) begin
      case (V_KIND[i])
        0: chk(got[i] == V_EXP[i], "R1 R2 first-use", got[i], V_EXP[i]);
        1: chk(got[i] == V_EXP[i], "R1 R3 reload", got[i], V_EXP[i]);
        default: chk(got[i] == V_EXP[i], "R4 R5 slot hit", got[i], V_EXP[i]);
      endcase
    end
    chk(err == 0, "R6 no error on valid stream", int'(err), 0);

    // Empty slot after start: error, no beat
    do_start();
    chk(err == 0 && out_valid == 0, "R7 start clears", int'(err) + int'(out_valid), 0);
    put(8'b1010_0000, 8); seal(); mode = 0;
    run_until(2);
    chk(err == 1, "R6 empty slot flags", int'(err), 1);
    chk(got[0] == 0 && got[1] == 1, "R6 no beat for bad slot", got[0], 0);

    // Restart: counter and cache fresh
    do_start();
    chk(err == 0, "R7 err cleared", int'(err), 0);
    put(8'b00_011_000, 8); seal();
    run_until(3);
    chk(got[0] == 0 && got[1] == 0 && got[2] == 1, "R7 counter restarts", got[2], 1);

    // Reload with counter at zero uses a one-bit field
    do_start();
    put(8'b010_1_0000, 8); seal();
    run_until(3);
    chk(got[0] == 1, "R3 clamp width", got[0], 1);
    chk(got[1] == 0 && got[2] == 1, "R3 bits after clamp", got[2], 1);

    // Backpressure hold and input stall
    do_start();
    for (int j = 0; j < 6; j++) put(0, 8);
    seal(); mode = 2;
    for (int t = 0; t < 20; t++) tick();
    held = int'(out_idx);
    chk(out_valid == 1 && held == 0, "R8 beat presented", held, 0);
    for (int t = 0; t < 5; t++) tick();
    chk(out_valid == 1 && int'(out_idx) == held, "R8 held stable", int'(out_idx), held);
    chk(in_ready == 0, "R9 input stalls when full", int'(in_ready), 0);
    mode = 0;
    run_until(24);
    chk(got[5] == 5 && got[23] == 23, "R9 R2 no bits lost", got[23], 23);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule